// File: doc/BRIEF.md
# External Bus Data Alignment Sequencer

This block sits between one internal bus master and an external memory bus that is sixteen bits wide. A single request (an address, a size of byte, word or longword, a direction and up to 32 bits of write data) is turned into a short series of external bus cycles. The number of cycles depends on the request size and on whether the addressed area is configured as an 8-bit or a 16-bit area. The address, the two byte-lane strobes, the write enable and the lane-wise output enables are all generated here. On reads, the returned bytes are packed back into one result word.

Data is big-endian. The most significant part goes out first, at the lowest address. The address then advances by one per cycle in an 8-bit area and by two per cycle in a 16-bit area. An 8-bit area uses only the upper lane (bits 15..8). A 16-bit area uses both lanes and picks lanes from the address and the size. Each external cycle takes two clocks: a setup clock and then a data clock. When the sequence ends, a one-clock done pulse is raised. A request that is misaligned, or that has an unknown size code, ends with done and an error flag and produces no bus activity.

Top module: `bus_align_seq`

## Requirements
- R1: After a synchronous active-low reset, busy, done, err, both strobes, the write enable and both output-enable bits are 0.
- R2: Size codes are 0 = byte, 1 = word, 2 = longword. In an area whose width bit is 0 (8-bit area), only the upper strobe `ext_ub` is asserted, and a byte, word or longword request takes 1, 2 or 4 bus cycles.
- R3: In an 8-bit area, cycle k uses address base+k and carries byte k counted from the most significant byte of the request. A write therefore leaves the request bytes in memory at ascending addresses, most significant first.
- R4: In a 16-bit area, a byte request takes one cycle. It uses the upper strobe and upper lane (bits 15..8) at an even address, and the lower strobe and lower lane (bits 7..0) at an odd address.
- R5: In a 16-bit area, a word request takes one cycle with both strobes. A longword request takes two cycles with both strobes, at base and base+2, with the upper word first.
- R6: A word request at an odd address, a longword request whose address is not a multiple of 4, and size code 3 all give `done` and `err` together one clock after acceptance, with no strobe ever asserted.
- R7: Every bus cycle lasts exactly two clocks. Address and strobes stay constant across both clocks, and strobes are asserted in both.
- R8: `busy` rises in the clock after a request is accepted and stays high up to and including the one-clock `done` pulse. Requests presented while busy are ignored.
- R9: During reads `ext_doe` is 0. During writes `ext_doe` equals {`ext_ub`, `ext_lb`} (bit 1 upper lane, bit 0 lower lane).
- R10: On read completion, `rd_data` holds the bytes read from ascending addresses, concatenated with the first byte most significant and right-aligned (upper bits zero). It is valid while `done` is high.
- R11: The area of a request is selected by the top log2(NUM_AREAS) address bits. The matching bit of `area_wide` (1 = 16-bit area) is sampled on acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| area_wide | input | NUM_AREAS | Per-area width bit, 1 = 16-bit area |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Misaligned or bad size, valid with done |
| rd_data | output | 32 | Reassembled read data |
| ext_addr | output | ADDR_W | External address |
| ext_ub | output | 1 | Upper lane strobe |
| ext_lb | output | 1 | Lower lane strobe |
| ext_we | output | 1 | External write enable |
| ext_din | input | 16 | Data bus input |
| ext_dout | output | 16 | Data bus output |
| ext_doe | output | 2 | Per-lane output enable, bit 1 upper |

## Verification
Two things can meet in one cycle. A new request can arrive while a sequence is in flight, and the final read capture lands on the same edge that raises done. The bench drives a second, different request a clock after acceptance of the first. It then requires that the logged cycles match only the first request and that the bus is idle and not busy in the clock after done. For reads, `rd_data` is sampled in the done cycle itself and compared with bytes gathered from the bench memory model. A wrong value there exposes a late or missing last capture.

// File: rtl/bas_pkg.sv
// Package: shared encodings for the bus alignment sequencer.
// Assumes a 16-bit external bus and a 32-bit internal data path.
package bas_pkg;
    localparam int BUS_W = 16;
    localparam int RES_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_DATA  = 2'd2,
        ST_FIN   = 2'd3
    } state_e;
endpackage

// File: rtl/bas_beat_plan.sv
// Module: bas_beat_plan
// Purpose: decides from address, size and area width whether a request is
// legal and how many external cycles it needs (returned as count minus one).
// Assumes: purely combinational; evaluated on the request inputs at accept.
module bas_beat_plan
    import bas_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              wide,
    output logic              misaligned,
    output logic [1:0]        last_idx
);
    // legality: word even, longword on 4-byte boundary, code 3 illegal
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_WORD: misaligned = addr[0];
            SZ_LONG: misaligned = (addr[1:0] != 2'b00);
            default: misaligned = 1'b1;
        endcase
    end

    // cycle count minus one: narrow moves a byte, wide moves up to a word
    always_comb begin
        unique case (size)
            SZ_BYTE: last_idx = 2'd0;
            SZ_WORD: last_idx = wide ? 2'd0 : 2'd1;
            SZ_LONG: last_idx = wide ? 2'd1 : 2'd3;
            default: last_idx = 2'd0;
        endcase
    end
endmodule

// File: rtl/bas_lane_steer.sv
// Module: bas_lane_steer
// Purpose: drives strobes, outgoing lane data and output enables for the
// current cycle index of a latched request.
// Assumes: idx never exceeds the planned last index; big-endian ordering.
module bas_lane_steer
    import bas_pkg::*;
(
    input  logic              active,
    input  logic              wide,
    input  logic [1:0]        size,
    input  logic              addr0,
    input  logic [1:0]        idx,
    input  logic              write,
    input  logic [RES_W-1:0]  wdata,
    output logic              ub,
    output logic              lb,
    output logic [BUS_W-1:0]  dout,
    output logic [1:0]        doe
);
    logic [1:0] top_byte;
    logic [1:0] byte_sel;
    logic       word_sel;
    logic [7:0] cur_byte;
    logic [15:0] cur_word;

    // index of the most significant byte of the request
    always_comb begin
        unique case (size)
            SZ_WORD: top_byte = 2'd1;
            SZ_LONG: top_byte = 2'd3;
            default: top_byte = 2'd0;
        endcase
    end

    // pick byte / word for this cycle, most significant first
    always_comb begin
        byte_sel = top_byte - idx;
        word_sel = (size == SZ_LONG) ? ~idx[0] : 1'b0;
        cur_byte = wdata[{byte_sel, 3'b000} +: 8];
        cur_word = word_sel ? wdata[31:16] : wdata[15:0];
    end

    // lane selection and data placement
    always_comb begin
        ub   = 1'b0;
        lb   = 1'b0;
        dout = '0;
        if (active) begin
            if (!wide) begin
                ub   = 1'b1;
                dout = {cur_byte, 8'h00};
            end else if (size == SZ_BYTE) begin
                ub   = ~addr0;
                lb   = addr0;
                dout = {cur_byte, cur_byte};
            end else begin
                ub   = 1'b1;
                lb   = 1'b1;
                dout = cur_word;
            end
        end
        doe = write ? {ub, lb} : 2'b00;
    end
endmodule

// File: rtl/bas_read_pack.sv
// Module: bas_read_pack
// Purpose: shifts each captured lane into a right-aligned result, first
// arrival ending up most significant.
// Assumes: clear and capture are never high together.
module bas_read_pack
    import bas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              wide,
    input  logic [1:0]        size,
    input  logic              addr0,
    input  logic [BUS_W-1:0]  din,
    output logic [RES_W-1:0]  rdata
);
    logic [7:0] lane_byte;

    // byte lane chosen for a byte-wide capture
    always_comb begin
        lane_byte = (wide && addr0) ? din[7:0] : din[15:8];
    end

    // accumulate read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (clear) begin
            rdata <= '0;
        end else if (capture) begin
            if (wide && size != SZ_BYTE) begin
                rdata <= {rdata[15:0], din};
            end else begin
                rdata <= {rdata[23:0], lane_byte};
            end
        end
    end
endmodule

// File: rtl/bus_align_seq.sv
// Module: bus_align_seq (top)
// Purpose: accepts one internal request at a time and sequences the external
// cycles it needs, two clocks per cycle (setup then data), then pulses done.
// Assumes: NUM_AREAS is a power of two >= 2; area chosen by top address bits.
module bus_align_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int NUM_AREAS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic                 req_write,
    input  logic [31:0]          req_wdata,
    input  logic [NUM_AREAS-1:0] area_wide,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [31:0]          rd_data,
    output logic [ADDR_W-1:0]    ext_addr,
    output logic                 ext_ub,
    output logic                 ext_lb,
    output logic                 ext_we,
    input  logic [15:0]          ext_din,
    output logic [15:0]          ext_dout,
    output logic [1:0]           ext_doe
);
    localparam int AREA_BITS = $clog2(NUM_AREAS);

    state_e            state_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        size_q;
    logic              write_q;
    logic [31:0]       wdata_q;
    logic              wide_q;
    logic              err_q;
    logic [1:0]        idx_q;
    logic [1:0]        last_q;

    logic              accept;
    logic              req_wide;
    logic              req_misal;
    logic [1:0]        req_last;
    logic              active;
    logic [ADDR_W-1:0] offs;

    // width bit of the area addressed by the incoming request
    always_comb begin
        req_wide = area_wide[req_addr[ADDR_W-1 -: AREA_BITS]];
        accept   = req_valid && (state_q == ST_IDLE);
        active   = (state_q == ST_SETUP) || (state_q == ST_DATA);
    end

    bas_beat_plan #(.ADDR_W(ADDR_W)) u_plan (
        .addr       (req_addr),
        .size       (req_size),
        .wide       (req_wide),
        .misaligned (req_misal),
        .last_idx   (req_last)
    );

    // sequencing state machine and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            size_q  <= 2'd0;
            write_q <= 1'b0;
            wdata_q <= '0;
            wide_q  <= 1'b0;
            err_q   <= 1'b0;
            idx_q   <= 2'd0;
            last_q  <= 2'd0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        base_q  <= req_addr;
                        size_q  <= req_size;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        wide_q  <= req_wide;
                        err_q   <= req_misal;
                        idx_q   <= 2'd0;
                        last_q  <= req_last;
                        state_q <= req_misal ? ST_FIN : ST_SETUP;
                    end
                end
                ST_SETUP: state_q <= ST_DATA;
                ST_DATA: begin
                    if (idx_q == last_q) begin
                        state_q <= ST_FIN;
                    end else begin
                        idx_q   <= idx_q + 2'd1;
                        state_q <= ST_SETUP;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    err_q   <= 1'b0;
                end
            endcase
        end
    end

    // external address: base plus cycle index scaled by lane count
    always_comb begin
        offs     = wide_q ? ADDR_W'({idx_q, 1'b0}) : ADDR_W'(idx_q);
        ext_addr = active ? (base_q + offs) : base_q;
        ext_we   = active && write_q;
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_FIN);
        err      = (state_q == ST_FIN) && err_q;
    end

    bas_lane_steer u_steer (
        .active (active),
        .wide   (wide_q),
        .size   (size_q),
        .addr0  (base_q[0]),
        .idx    (idx_q),
        .write  (write_q),
        .wdata  (wdata_q),
        .ub     (ext_ub),
        .lb     (ext_lb),
        .dout   (ext_dout),
        .doe    (ext_doe)
    );

    bas_read_pack u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture ((state_q == ST_DATA) && !write_q),
        .wide    (wide_q),
        .size    (size_q),
        .addr0   (base_q[0]),
        .din     (ext_din),
        .rdata   (rd_data)
    );

    // assertions guarding sequencing and lane use
    AST_NARROW_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wide_q) |-> !ext_lb);                                  // R2
    AST_WIDE_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wide_q && size_q == SZ_BYTE) |-> $onehot0({ext_ub, ext_lb})); // R4
    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !(ext_ub || ext_lb));                                     // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> ($stable(ext_addr) && $stable({ext_ub, ext_lb}))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R8
    AST_BUSY_ENDS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));                                     // R8
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !write_q) |-> (ext_doe == 2'b00));                       // R9
endmodule

// File: tb/tb_bus_align_seq.sv
module tb_bus_align_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  area_wide = 8'b1100_1010;
    logic        busy, done, err;
    logic [31:0] rd_data;
    logic [23:0] ext_addr;
    logic        ext_ub, ext_lb, ext_we;
    logic [15:0] ext_din, ext_dout;
    logic [1:0]  ext_doe;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];

    always #2 clk = ~clk;   // 250 MHz

    bus_align_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .area_wide(area_wide), .busy(busy), .done(done), .err(err),
        .rd_data(rd_data), .ext_addr(ext_addr), .ext_ub(ext_ub), .ext_lb(ext_lb),
        .ext_we(ext_we), .ext_din(ext_din), .ext_dout(ext_dout), .ext_doe(ext_doe)
    );

    // memory model answering on the lanes of the addressed area
    logic       cur_wide;
    logic [7:0] la;
    assign cur_wide = area_wide[ext_addr[23:21]];
    assign la       = ext_addr[7:0];
    assign ext_din  = cur_wide ? {mem[{la[7:1], 1'b0}], mem[{la[7:1], 1'b1}]}
                               : {mem[la], 8'h00};

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int exp_cycles(input bit wide, input logic [1:0] sz);
        if (sz == 2'd0) return 1;
        if (sz == 2'd1) return wide ? 1 : 2;
        return wide ? 2 : 4;
    endfunction

    function automatic bit exp_bad(input logic [23:0] a, input logic [1:0] sz);
        if (sz == 2'd3) return 1;
        if (sz == 2'd1) return a[0];
        if (sz == 2'd2) return a[1:0] != 2'b00;
        return 0;
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    task automatic txn(input logic [23:0] a, input logic [1:0] sz, input bit wr,
                       input logic [31:0] wd, input bit inject);
        bit          wide = area_wide[a[23:21]];
        bit          bad  = exp_bad(a, sz);
        int          ncyc = bad ? 0 : exp_cycles(wide, sz);
        int          nb   = nbytes(sz);
        logic [23:0] lg_addr [16];
        logic [1:0]  lg_strb [16];
        int          nlog = 0;
        int          cyc  = 0;
        bit          busy_bad = 0, doe_bad = 0, hung = 0;
        logic [31:0] exp_rd = '0;
        logic [1:0]  es;
        logic [23:0] ea;
        bit          pair_ok, addr_ok, strb_ok, mem_ok;

        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        if (!bad && sz != 2'd3) begin
            for (int i = 0; i < nb; i++) begin
                exp_rd = {exp_rd[23:0], mem[8'(a[7:0] + 8'(i))]};
                if (wr) exp_mem[8'(a[7:0] + 8'(i))] = wd[(nb-1-i)*8 +: 8];
            end
        end
        @(negedge clk);
        req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            if (inject && cyc == 1) begin
                req_addr = a ^ 24'h000010; req_size = 2'd0; req_write = ~wr; req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            if (!busy) busy_bad = 1;
            if (ext_doe != (wr ? {ext_ub, ext_lb} : 2'b00)) doe_bad = 1;
            if (ext_ub || ext_lb) begin
                if (nlog < 16) begin
                    lg_addr[nlog] = ext_addr;
                    lg_strb[nlog] = {ext_ub, ext_lb};
                end
                nlog++;
                if (ext_we) begin
                    if (!cur_wide) mem[la] = ext_dout[15:8];
                    else begin
                        if (ext_ub) mem[{la[7:1], 1'b0}] = ext_dout[15:8];
                        if (ext_lb) mem[{la[7:1], 1'b1}] = ext_dout[7:0];
                    end
                end
            end
            if (done) break;
            cyc++;
            if (cyc > 40) begin hung = 1; break; end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(!hung, "R8 done reached", 64'(hung), 0);
        chk(!busy_bad, "R8 busy held until done", 64'(busy_bad), 0);
        chk(err == bad, "R6 err flag", 64'(err), 64'(bad));
        chk(nlog == 2*ncyc, "R2 R5 R7 strobed clocks", 64'(nlog), 64'(2*ncyc));
        chk(!doe_bad, "R9 output enable", 64'(doe_bad), 0);
        pair_ok = 1; addr_ok = 1; strb_ok = 1;
        for (int k = 0; k < ncyc && 2*k+1 < 16 && 2*k+1 < nlog; k++) begin
            if (lg_addr[2*k] != lg_addr[2*k+1] || lg_strb[2*k] != lg_strb[2*k+1]) pair_ok = 0;
            ea = a + 24'(wide ? 2*k : k);
            if (lg_addr[2*k] != ea) addr_ok = 0;
            if (!wide) es = 2'b10;
            else if (sz == 2'd0) es = a[0] ? 2'b01 : 2'b10;
            else es = 2'b11;
            if (lg_strb[2*k] != es) strb_ok = 0;
        end
        chk(pair_ok, "R7 two-clock cycles stable", 64'(pair_ok), 1);
        chk(addr_ok, wide ? "R5 wide address step" : "R3 narrow address step", 64'(addr_ok), 1);
        chk(strb_ok, wide ? "R4 R5 R11 wide lanes" : "R2 R11 narrow lanes", 64'(strb_ok), 1);
        if (wr || bad) begin
            mem_ok = 1;
            for (int i = 0; i < 256; i++) if (mem[i] != exp_mem[i]) mem_ok = 0;
            chk(mem_ok, "R3 R4 R5 write placement", 64'(mem_ok), 1);
        end else begin
            chk(rd_data == exp_rd, "R10 read reassembly", 64'(rd_data), 64'(exp_rd));
        end
        @(negedge clk);
        chk(!busy && !ext_ub && !ext_lb, "R8 idle after done, extra request ignored",
            64'({busy, ext_ub, ext_lb}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] a;
        logic [1:0]  sz;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        chk({busy, done, err, ext_ub, ext_lb, ext_we, ext_doe} == 0, "R1 reset outputs",
            64'({busy, done, err, ext_ub, ext_lb, ext_we, ext_doe}), 0);
        rst_n = 1'b1;
        // directed: area 0 narrow, area 1 wide (R11)
        txn(24'h000040, 2'd0, 1'b0, 0, 0);
        txn(24'h000041, 2'd1, 1'b1, 32'h0000_A1B2, 0);
        txn(24'h000041, 2'd1, 1'b0, 0, 0);
        txn(24'h000044, 2'd2, 1'b1, 32'hC0DE_F00D, 0);
        txn(24'h000044, 2'd2, 1'b0, 0, 0);
        txn(24'h200080, 2'd0, 1'b1, 32'h0000_005A, 0);
        txn(24'h200081, 2'd0, 1'b1, 32'h0000_00A5, 0);
        txn(24'h200081, 2'd0, 1'b0, 0, 0);
        txn(24'h200090, 2'd1, 1'b1, 32'h0000_1234, 0);
        txn(24'h2000A0, 2'd2, 1'b1, 32'h89AB_CDEF, 0);
        txn(24'h2000A0, 2'd2, 1'b0, 0, 0);
        txn(24'h200091, 2'd1, 1'b0, 0, 0);
        txn(24'h2000A2, 2'd2, 1'b1, 32'h1111_2222, 0);
        txn(24'h000050, 2'd3, 1'b0, 0, 0);
        txn(24'h2000B0, 2'd2, 1'b0, 0, 1);
        txn(24'h000060, 2'd2, 1'b1, 32'h7766_5544, 1);
        for (int n = 0; n < 200; n++) begin
            sz = 2'($urandom % 4);
            a  = {3'($urandom % 8), 13'd0, 8'($urandom)};
            if ($urandom % 5 != 0) begin
                if (sz == 2'd1) a[0] = 1'b0;
                if (sz == 2'd2) a[1:0] = 2'b00;
            end
            txn(a, sz, 1'($urandom), $urandom, ($urandom % 8) == 0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule